// File: doc/BRIEF.md
# Three-Phase Gate Protection Logic

This block sits between a motor controller's six PWM commands and the six gate enables of a three-phase inverter bridge. Each phase has an upper and a lower command. The block also receives digitised status flags: one overcurrent flag, one flag for undervoltage on the main driver supply, and one undervoltage flag for each upper-switch supply. Every command and flag passes through a two-flop synchroniser first. Commands then go through a minimum-width filter, so very short pulses never reach a gate.

Shoot-through is prevented in logic. If a phase asks for both switches at once, that phase is turned fully off. An overcurrent shuts down all six gates and pulls the active-low fault output. The fault is not latched. It releases itself once the overcurrent has stayed away for a programmable number of clock cycles, and any new overcurrent during that wait starts the wait again. Main-supply undervoltage removes all gates for as long as it lasts, and outputs come back as soon as it clears. An upper-supply undervoltage removes only that phase's upper gate, and that gate stays blocked until the phase's upper command has been seen low. Undervoltage never drives the fault output.

Top module: `phase_gate_guard`

## Requirements
- R1: During and just after reset, all six gate enables are 0 and `faultN` is 1.
- R2: For each phase, once the filtered commands are settled: upper-only drives only the upper gate, lower-only drives only the lower gate, and neither drives no gate.
- R3: A phase whose upper and lower commands are both 1 has both gates at 0. Other phases are unaffected.
- R4: While `ocFlag` is 1, all six gates go to 0 and `faultN` goes to 0 within a few cycles.
- R5: After `ocFlag` returns to 0, `faultN` stays 0 and the gates stay off for REC_CYC cycles. After that, `faultN` returns to 1 and the gates follow the commands again with no change of input.
- R6: An overcurrent that returns while the recovery wait is running restarts the full REC_CYC wait, counted from its own release.
- R7: While `mainUvFlag` is 1, all six gates are 0 and `faultN` stays 1. When the flag clears, both upper and lower gates resume at once without the commands being cycled.
- R8: `hsUvFlag[i]` = 1 turns off only upper gate i. Lower gates, other phases and `faultN` are unchanged.
- R9: After `hsUvFlag[i]` clears, upper gate i stays off until `hiCmd[i]` has been filtered as 0. A later 1 then drives the gate again.
- R10: A command level reaches the gate logic only after it has been held for FILT_CYC consecutive synchronised cycles. A pulse, high or low, shorter than that has no effect on the gates.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| hiCmd | input | 3 | Upper-switch PWM command, bit i = phase i |
| loCmd | input | 3 | Lower-switch PWM command, bit i = phase i |
| ocFlag | input | 1 | Overcurrent detected (1 = over limit) |
| mainUvFlag | input | 1 | Main driver supply undervoltage (1 = low) |
| hsUvFlag | input | 3 | Per-phase upper supply undervoltage (1 = low) |
| hiGate | output | 3 | Upper gate enables, bit i = phase i |
| loGate | output | 3 | Lower gate enables, bit i = phase i |
| faultN | output | 1 | Open-drain pad enable, 0 = pull low (overcurrent), 1 = release |

## Verification
The assertions assume that every flag and command is a clean digital level, so nothing after the synchroniser sees a metastable value. They also assume that a change of status takes effect one synchronised cycle later, so a strobe raised in one cycle is judged by the registered gates in the next. The stimulus changes inputs only on the falling clock edge. It holds commands well beyond the filter length, except where a short pulse is the point of a test. Each check waits out the synchroniser, filter and output register delays before it samples.

// File: rtl/gg_pkg.sv
package gg_pkg;
  localparam int PHASES = 3;

  typedef struct packed {
    logic              gateKill;
    logic [PHASES-1:0] hiBlock;
  } guardStrobe_t;
endpackage

// File: rtl/gg_sync.sv
module gg_sync #(
  parameter int WIDTH  = 1,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  logic [STAGES-1:0][WIDTH-1:0] pipe;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pipe <= '0;
    end else begin
      pipe[0] <= din;
      for (int k = 1; k < STAGES; k++) pipe[k] <= pipe[k-1];
    end
  end

  assign dout = pipe[STAGES-1];
endmodule

// File: rtl/gg_filter.sv
module gg_filter #(
  parameter int HOLD = 4
) (
  input  logic clk,
  input  logic rstN,
  input  logic fIn,
  output logic fOut
);
  generate
    if (HOLD <= 1) begin : g_pass
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) fOut <= 1'b0;
        else       fOut <= fIn;
      end
    end else begin : g_count
      localparam int CW = $clog2(HOLD);
      logic [CW-1:0] cnt;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          fOut <= 1'b0;
          cnt  <= '0;
        end else if (fIn == fOut) begin
          cnt <= '0;
        end else if (cnt == CW'(HOLD - 1)) begin
          fOut <= fIn;
          cnt  <= '0;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  endgenerate

  // R10: the filtered level only moves to a value the input is showing
  a_r10_settled_change: assert property (@(posedge clk) disable iff (!rstN)
    (fOut != $past(fOut)) |-> (fOut == $past(fIn)));
endmodule

// File: rtl/gg_ctrl.sv
module gg_ctrl
  import gg_pkg::*;
#(
  parameter int REC_CYC = 8000000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ocSync,
  input  logic              mainUvSync,
  input  logic [PHASES-1:0] hsUvSync,
  input  logic [PHASES-1:0] hiFilt,
  output guardStrobe_t      strobe,
  output logic              faultN
);
  localparam int RW = (REC_CYC > 1) ? $clog2(REC_CYC) : 1;

  logic          ocFault;
  logic [RW-1:0] recCnt;
  logic [PHASES-1:0] hsBlock;

  // overcurrent fault with self-clearing recovery window
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ocFault <= 1'b0;
      recCnt  <= '0;
    end else if (ocSync) begin
      ocFault <= 1'b1;
      recCnt  <= '0;
    end else if (ocFault) begin
      if (recCnt == RW'(REC_CYC - 1)) begin
        ocFault <= 1'b0;
        recCnt  <= '0;
      end else begin
        recCnt <= recCnt + 1'b1;
      end
    end
  end

  // per-phase upper-supply block, released only with a low command
  generate
    for (genvar i = 0; i < PHASES; i++) begin : g_hs
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)             hsBlock[i] <= 1'b0;
        else if (hsUvSync[i])  hsBlock[i] <= 1'b1;
        else if (!hiFilt[i])   hsBlock[i] <= 1'b0;
      end

      // R9: a block survives while the upper command stays high
      a_r9_hold_block: assert property (@(posedge clk) disable iff (!rstN)
        (hsBlock[i] && hiFilt[i]) |=> hsBlock[i]);
    end
  endgenerate

  assign strobe.gateKill = ocFault | ocSync | mainUvSync;
  assign strobe.hiBlock  = hsBlock | hsUvSync;
  assign faultN          = ~ocFault;

  // R4: overcurrent drives the pad low on the next cycle
  a_r4_fault_on_oc: assert property (@(posedge clk) disable iff (!rstN)
    ocSync |=> !faultN);

  // R5: the pad is never released in the cycle right after an overcurrent
  a_r5_quiet_release: assert property (@(posedge clk) disable iff (!rstN)
    $rose(faultN) |-> !$past(ocSync));
endmodule

// File: rtl/gg_datapath.sv
module gg_datapath
  import gg_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [PHASES-1:0] hiFilt,
  input  logic [PHASES-1:0] loFilt,
  input  guardStrobe_t      strobe,
  output logic [PHASES-1:0] hiGate,
  output logic [PHASES-1:0] loGate
);
  logic [PHASES-1:0] hiNext, loNext, allowMask;

  always_comb begin
    allowMask = {PHASES{~strobe.gateKill}};
    hiNext    = hiFilt & ~loFilt & ~strobe.hiBlock & allowMask;
    loNext    = loFilt & ~hiFilt & allowMask;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hiGate <= '0;
      loGate <= '0;
    end else begin
      hiGate <= hiNext;
      loGate <= loNext;
    end
  end

  // R3: never both switches of one phase
  a_r3_no_shoot_through: assert property (@(posedge clk) disable iff (!rstN)
    (hiGate & loGate) == '0);

  // R7: any kill strobe empties every gate one cycle later
  a_r7_kill_all: assert property (@(posedge clk) disable iff (!rstN)
    strobe.gateKill |=> (hiGate == '0 && loGate == '0));

  // R8: blocked upper switches stay off
  a_r8_upper_blocked: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.hiBlock != '0) |=> ((hiGate & $past(strobe.hiBlock)) == '0));

  // R2: lower gates follow a lower-only command when nothing kills them
  a_r2_lower_follows: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.gateKill |=> (loGate == $past(loFilt & ~hiFilt)));
endmodule

// File: rtl/phase_gate_guard.sv
module phase_gate_guard
  import gg_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int FILT_CYC    = 200,
  parameter int REC_CYC     = 8000000
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [2:0] hiCmd,
  input  logic [2:0] loCmd,
  input  logic       ocFlag,
  input  logic       mainUvFlag,
  input  logic [2:0] hsUvFlag,
  output logic [2:0] hiGate,
  output logic [2:0] loGate,
  output logic       faultN
);
  localparam int CMD_W  = 2 * PHASES;
  localparam int SYNC_W = CMD_W + 2 + PHASES;

  logic [SYNC_W-1:0] rawIn, syncOut;
  logic [CMD_W-1:0]  cmdSync, cmdFilt;
  logic              ocSync, mainUvSync;
  logic [PHASES-1:0] hsUvSync;
  guardStrobe_t      strobe;

  assign rawIn = {hsUvFlag, mainUvFlag, ocFlag, loCmd, hiCmd};

  gg_sync #(.WIDTH(SYNC_W), .STAGES(SYNC_STAGES)) uSync (
    .clk(clk), .rstN(rstN), .din(rawIn), .dout(syncOut)
  );

  assign cmdSync    = syncOut[CMD_W-1:0];
  assign ocSync     = syncOut[CMD_W];
  assign mainUvSync = syncOut[CMD_W+1];
  assign hsUvSync   = syncOut[SYNC_W-1:CMD_W+2];

  generate
    for (genvar g = 0; g < CMD_W; g++) begin : g_filt
      gg_filter #(.HOLD(FILT_CYC)) uFilt (
        .clk(clk), .rstN(rstN), .fIn(cmdSync[g]), .fOut(cmdFilt[g])
      );
    end
  endgenerate

  gg_ctrl #(.REC_CYC(REC_CYC)) uCtrl (
    .clk(clk), .rstN(rstN),
    .ocSync(ocSync), .mainUvSync(mainUvSync), .hsUvSync(hsUvSync),
    .hiFilt(cmdFilt[PHASES-1:0]),
    .strobe(strobe), .faultN(faultN)
  );

  gg_datapath uData (
    .clk(clk), .rstN(rstN),
    .hiFilt(cmdFilt[PHASES-1:0]), .loFilt(cmdFilt[CMD_W-1:PHASES]),
    .strobe(strobe),
    .hiGate(hiGate), .loGate(loGate)
  );
endmodule

// File: tb/sim_phase_gate_guard.sv
`timescale 1ns/1ps
module sim_phase_gate_guard;
  localparam int FILT = 4;
  localparam int REC  = 60;
  localparam int SETTLE = 14;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [2:0] hiCmd = '0, loCmd = '0, hsUvFlag = '0;
  logic ocFlag = 1'b0, mainUvFlag = 1'b0;
  logic [2:0] hiGate, loGate;
  logic faultN;

  int nTests = 0;
  int nFail  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  phase_gate_guard #(.SYNC_STAGES(2), .FILT_CYC(FILT), .REC_CYC(REC)) u0 (
    .clk(clk), .rstN(rstN), .hiCmd(hiCmd), .loCmd(loCmd),
    .ocFlag(ocFlag), .mainUvFlag(mainUvFlag), .hsUvFlag(hsUvFlag),
    .hiGate(hiGate), .loGate(loGate), .faultN(faultN)
  );

  task automatic waitc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [2:0] eH, input logic [2:0] eL,
                     input logic eF);
    nTests++;
    if (hiGate !== eH || loGate !== eL || faultN !== eF) begin
      nFail++;
      $display("FAIL %s: hi=%b lo=%b faultN=%b expected hi=%b lo=%b faultN=%b",
               tag, hiGate, loGate, faultN, eH, eL, eF);
    end
  endtask

  task automatic t_reset;
    waitc(3);
    chk("R1 in reset", 3'b000, 3'b000, 1'b1);
    rstN = 1'b1;
    waitc(SETTLE);
    chk("R1 after reset", 3'b000, 3'b000, 1'b1);
  endtask

  task automatic t_decode;
    hiCmd = 3'b101; loCmd = 3'b010; waitc(SETTLE);
    chk("R2 pattern A", 3'b101, 3'b010, 1'b1);
    hiCmd = 3'b010; loCmd = 3'b101; waitc(SETTLE);
    chk("R2 pattern B", 3'b010, 3'b101, 1'b1);
    hiCmd = 3'b000; loCmd = 3'b000; waitc(SETTLE);
    chk("R2 idle", 3'b000, 3'b000, 1'b1);
  endtask

  task automatic t_shoot;
    hiCmd = 3'b011; loCmd = 3'b110; waitc(SETTLE);
    chk("R3 phase1 both", 3'b001, 3'b100, 1'b1);
    hiCmd = 3'b111; loCmd = 3'b111; waitc(SETTLE);
    chk("R3 all both", 3'b000, 3'b000, 1'b1);
    hiCmd = 3'b000; loCmd = 3'b000; waitc(SETTLE);
  endtask

  task automatic t_filter;
    bit seen = 1'b0;
    bit dropped = 1'b0;
    hiCmd = 3'b001; waitc(FILT - 2); hiCmd = 3'b000;
    for (int k = 0; k < SETTLE; k++) begin
      waitc(1);
      if (hiGate[0]) seen = 1'b1;
    end
    nTests++;
    if (seen) begin
      nFail++;
      $display("FAIL R10 short high pulse: gate rose=1 expected 0");
    end
    hiCmd = 3'b001; waitc(SETTLE);
    chk("R10 held high", 3'b001, 3'b000, 1'b1);
    hiCmd = 3'b000; waitc(FILT - 2); hiCmd = 3'b001;
    for (int k = 0; k < SETTLE; k++) begin
      waitc(1);
      if (!hiGate[0]) dropped = 1'b1;
    end
    nTests++;
    if (dropped) begin
      nFail++;
      $display("FAIL R10 short low pulse: gate dropped=1 expected 0");
    end
    hiCmd = 3'b000; waitc(SETTLE);
  endtask

  task automatic t_oc;
    hiCmd = 3'b100; loCmd = 3'b011; waitc(SETTLE);
    chk("R4 before", 3'b100, 3'b011, 1'b1);
    ocFlag = 1'b1; waitc(5);
    chk("R4 tripped", 3'b000, 3'b000, 1'b0);
    ocFlag = 1'b0; waitc(REC - 4);
    chk("R5 still waiting", 3'b000, 3'b000, 1'b0);
    waitc(12);
    chk("R5 recovered", 3'b100, 3'b011, 1'b1);
  endtask

  task automatic t_retrig;
    ocFlag = 1'b1; waitc(5); ocFlag = 1'b0;
    waitc(30);
    ocFlag = 1'b1; waitc(3); ocFlag = 1'b0;
    waitc(REC - 4);
    chk("R6 restarted wait", 3'b000, 3'b000, 1'b0);
    waitc(12);
    chk("R6 recovered", 3'b100, 3'b011, 1'b1);
  endtask

  task automatic t_mainuv;
    hiCmd = 3'b001; loCmd = 3'b110; waitc(SETTLE);
    mainUvFlag = 1'b1; waitc(5);
    chk("R7 main uv off", 3'b000, 3'b000, 1'b1);
    mainUvFlag = 1'b0; waitc(5);
    chk("R7 main uv resume", 3'b001, 3'b110, 1'b1);
  endtask

  task automatic t_hsuv;
    hiCmd = 3'b101; loCmd = 3'b010; waitc(SETTLE);
    hsUvFlag = 3'b001; waitc(5);
    chk("R8 phase0 upper only", 3'b100, 3'b010, 1'b1);
  endtask

  task automatic t_hslatch;
    hsUvFlag = 3'b000; waitc(10);
    chk("R9 still blocked", 3'b100, 3'b010, 1'b1);
    hiCmd = 3'b100; waitc(SETTLE);
    chk("R9 command low", 3'b100, 3'b010, 1'b1);
    hiCmd = 3'b101; waitc(SETTLE);
    chk("R9 released", 3'b101, 3'b010, 1'b1);
  endtask

  initial begin
    t_reset();
    t_decode();
    t_shoot();
    t_filter();
    t_oc();
    t_retrig();
    t_mainuv();
    t_hsuv();
    t_hslatch();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nTests++;
      nFail++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("[TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  end
endmodule